// File: doc/BRIEF.md
# Dual-Rail Tamper-Propagating Gate Network

This block carries every logical bit on two wires and evaluates a small fixed gate network in that form. A logical 1 travels as the pair 10 and a logical 0 as 01. The pair 00 is a poison symbol that marks a wire as tampered. Each encoded XOR and AND is a sum of products over the input wires and their complements. Inverters appear only where input wires enter a gate. For this reason, pulling any wire low can turn a valid pair into 00 but can never produce 11. The encoded NOT exchanges the two wires of a pair.

The network repeats over `LANES` independent lanes. In lane i it computes y = (a XOR b) AND (NOT c). The three inputs are encoded, and the result pair is decoded back to a single bit. Force-low masks sit on the encoder outputs, on the XOR result and on the AND result, so a testbench can pull any chosen wire to 0. A combinational flag reports whether any internal pair reads 11.

Top module: `dualrail_net`

## Requirements
- R1: For a lane with bit v, the encoded pair is {v, ~v}. Lane i occupies bits [2i+1:2i] of every pair-wide port, and bit 2i+1 is the first wire. So 1 is 10 and 0 is 01.
- R2: When both XOR inputs are valid pairs, the XOR pair encodes the exclusive-or of their logical values.
- R3: When both AND inputs are valid pairs, the AND pair encodes the logical AND of their values.
- R4: The NOT pair is the input pair with its two wires exchanged, so a valid pair is inverted and 00 stays 00.
- R5: If either input pair of the XOR or the AND gadget is 00, that gadget outputs 00.
- R6: Under any force-low mask, every gadget output is either the value it would take with clean inputs or 00.
- R7: No internal pair ever equals 11, and the flag `eleven_o` stays 0 under every input and mask pattern.
- R8: The decoded output bit equals the first wire of the final pair, so a 00 result decodes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | LANES | Logical input a per lane |
| b_i | input | LANES | Logical input b per lane |
| c_i | input | LANES | Logical input c per lane |
| kill_a_i | input | 2*LANES | Force-low mask on encoded a wires |
| kill_b_i | input | 2*LANES | Force-low mask on encoded b wires |
| kill_c_i | input | 2*LANES | Force-low mask on encoded c wires |
| kill_x_i | input | 2*LANES | Force-low mask on XOR result wires |
| kill_y_i | input | 2*LANES | Force-low mask on AND result wires |
| ea_o | output | 2*LANES | Encoded a pairs after masking |
| eb_o | output | 2*LANES | Encoded b pairs after masking |
| ec_o | output | 2*LANES | Encoded c pairs after masking |
| x_o | output | 2*LANES | XOR result pairs after masking |
| nc_o | output | 2*LANES | NOT of encoded c pairs |
| y_o | output | 2*LANES | AND result pairs after masking |
| bit_o | output | LANES | Decoded result bit per lane |
| eleven_o | output | 1 | High if any internal pair reads 11 |

## Verification
The block is purely combinational, so every output is due in the same cycle as the stimulus that causes it, with no register on any path. The bench drives the inputs and masks just after a falling clock edge. It samples all outputs 1 ns later, well before the next rising edge, so the value seen is settled and no cycle offset needs to be counted. The expected pairs are rebuilt in the bench from pair semantics: the masks are applied and 00 is propagated, without reusing the gadget sum-of-products terms.

// File: rtl/dualrail_net.sv
module dualrail_net #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]   a_i,
  input  logic [LANES-1:0]   b_i,
  input  logic [LANES-1:0]   c_i,
  input  logic [2*LANES-1:0] kill_a_i,
  input  logic [2*LANES-1:0] kill_b_i,
  input  logic [2*LANES-1:0] kill_c_i,
  input  logic [2*LANES-1:0] kill_x_i,
  input  logic [2*LANES-1:0] kill_y_i,
  output logic [2*LANES-1:0] ea_o,
  output logic [2*LANES-1:0] eb_o,
  output logic [2*LANES-1:0] ec_o,
  output logic [2*LANES-1:0] x_o,
  output logic [2*LANES-1:0] nc_o,
  output logic [2*LANES-1:0] y_o,
  output logic [LANES-1:0]   bit_o,
  output logic               eleven_o
);

  localparam int PW = 2 * LANES;

  function automatic logic [1:0] enc(input logic v);
    return {v, ~v};
  endfunction

  function automatic logic [1:0] g_xor(input logic [1:0] p, input logic [1:0] q);
    logic ph, pl, qh, ql, phn, pln, qhn, qln;
    ph = p[1]; pl = p[0]; qh = q[1]; ql = q[0];
    phn = ~ph; pln = ~pl; qhn = ~qh; qln = ~ql;
    g_xor[1] = (ph & pln & qhn & ql) | (phn & pl & qh & qln);
    g_xor[0] = (ph & pln & qh & qln) | (phn & pl & qhn & ql);
  endfunction

  function automatic logic [1:0] g_and(input logic [1:0] p, input logic [1:0] q);
    logic ph, pl, qh, ql, phn, pln, qhn, qln;
    ph = p[1]; pl = p[0]; qh = q[1]; ql = q[0];
    phn = ~ph; pln = ~pl; qhn = ~qh; qln = ~ql;
    g_and[1] = ph & pln & qh & qln;
    g_and[0] = (phn & pl & qhn & ql) | (phn & pl & qh & qln) | (ph & pln & qhn & ql);
  endfunction

  function automatic logic [1:0] g_not(input logic [1:0] p);
    return {p[0], p[1]};
  endfunction

  logic [PW-1:0]    lane_bad;
  logic [LANES-1:0] lane_eleven;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0] ea, eb, ec, x, nc, y;
    assign ea = enc(a_i[i]) & ~kill_a_i[2*i+1 -: 2];
    assign eb = enc(b_i[i]) & ~kill_b_i[2*i+1 -: 2];
    assign ec = enc(c_i[i]) & ~kill_c_i[2*i+1 -: 2];
    assign x  = g_xor(ea, eb) & ~kill_x_i[2*i+1 -: 2];
    assign nc = g_not(ec);
    assign y  = g_and(x, nc) & ~kill_y_i[2*i+1 -: 2];

    assign ea_o[2*i+1 -: 2] = ea;
    assign eb_o[2*i+1 -: 2] = eb;
    assign ec_o[2*i+1 -: 2] = ec;
    assign x_o[2*i+1 -: 2]  = x;
    assign nc_o[2*i+1 -: 2] = nc;
    assign y_o[2*i+1 -: 2]  = y;
    assign bit_o[i] = y[1];

    assign lane_eleven[i] = (&ea) | (&eb) | (&ec) | (&x) | (&nc) | (&y);
    assign lane_bad[2*i+1 -: 2] = {1'b0, lane_eleven[i]};

    always_comb begin
      AST_XOR_POISON: assert (!(ea === 2'b00 || eb === 2'b00) || x === 2'b00); // R5
      AST_AND_POISON: assert (!(x === 2'b00 || nc === 2'b00) || y === 2'b00); // R5
      AST_XOR_VALUE: assert (!((ea === 2'b10 || ea === 2'b01) && (eb === 2'b10 || eb === 2'b01)
                               && kill_x_i[2*i+1 -: 2] === 2'b00)
                             || x === {ea[1] ^ eb[1], ~(ea[1] ^ eb[1])}); // R2
      AST_AND_VALUE: assert (!((x === 2'b10 || x === 2'b01) && (nc === 2'b10 || nc === 2'b01)
                               && kill_y_i[2*i+1 -: 2] === 2'b00)
                             || y === {x[1] & nc[1], ~(x[1] & nc[1])}); // R3
      AST_NO_ELEVEN: assert (y !== 2'b11 && x !== 2'b11); // R7
    end
  end

  assign eleven_o = |lane_bad;

endmodule

// File: tb/dualrail_net_tb.sv
module dualrail_net_tb_top;
  localparam int L  = 4;
  localparam int PW = 2 * L;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [L-1:0]  a, b, c;
  logic [PW-1:0] ka, kb, kc, kx, ky;
  logic [PW-1:0] ea, eb, ec, x, nc, y;
  logic [L-1:0]  bo;
  logic          el;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  dualrail_net #(.LANES(L)) dut_i (
    .a_i(a), .b_i(b), .c_i(c),
    .kill_a_i(ka), .kill_b_i(kb), .kill_c_i(kc), .kill_x_i(kx), .kill_y_i(ky),
    .ea_o(ea), .eb_o(eb), .ec_o(ec), .x_o(x), .nc_o(nc), .y_o(y),
    .bit_o(bo), .eleven_o(el)
  );

  function automatic logic [1:0] r_enc(input logic v);
    return v ? 2'b10 : 2'b01;
  endfunction
  function automatic logic [1:0] r_xor(input logic [1:0] p, input logic [1:0] q);
    if (p == 2'b00 || q == 2'b00) return 2'b00;
    return r_enc(p[1] != q[1]);
  endfunction
  function automatic logic [1:0] r_and(input logic [1:0] p, input logic [1:0] q);
    if (p == 2'b00 || q == 2'b00) return 2'b00;
    return r_enc(p == 2'b10 && q == 2'b10);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [L-1:0] ia, ib, ic, input logic [PW-1:0] fa, fb, fc, fx, fy);
    logic [PW-1:0] xa, xb, xc, xx, xn, xy;
    logic [L-1:0]  xbit;
    @(negedge clk);
    a = ia; b = ib; c = ic; ka = fa; kb = fb; kc = fc; kx = fx; ky = fy;
    for (int i = 0; i < L; i++) begin
      xa[2*i+1 -: 2] = r_enc(ia[i]) & ~fa[2*i+1 -: 2];
      xb[2*i+1 -: 2] = r_enc(ib[i]) & ~fb[2*i+1 -: 2];
      xc[2*i+1 -: 2] = r_enc(ic[i]) & ~fc[2*i+1 -: 2];
      xx[2*i+1 -: 2] = r_xor(xa[2*i+1 -: 2], xb[2*i+1 -: 2]) & ~fx[2*i+1 -: 2];
      xn[2*i+1 -: 2] = {xc[2*i], xc[2*i+1]};
      xy[2*i+1 -: 2] = r_and(xx[2*i+1 -: 2], xn[2*i+1 -: 2]) & ~fy[2*i+1 -: 2];
      xbit[i] = xy[2*i+1];
    end
    #1;
    chk("R1 encoder a", 32'(ea), 32'(xa));
    chk("R1 encoder b/c", 32'({eb, ec}), 32'({xb, xc}));
    chk("R2/R5/R6 xor", 32'(x), 32'(xx));
    chk("R4 not", 32'(nc), 32'(xn));
    chk("R3/R5/R6 and", 32'(y), 32'(xy));
    chk("R8 decode", 32'(bo), 32'(xbit));
    chk("R7 eleven", 32'(el), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    a = '0; b = '0; c = '0; ka = '0; kb = '0; kc = '0; kx = '0; ky = '0;
    // R1 R2 R3 R4 R8: all valid combinations in every lane
    for (int v = 0; v < 8; v++)
      apply({L{v[0]}}, {L{v[1]}}, {L{v[2]}}, '0, '0, '0, '0, '0);
    for (int n = 0; n < 40; n++)
      apply(L'($urandom), L'($urandom), L'($urandom), '0, '0, '0, '0, '0);
    // R5 directed: poison on each input pair
    apply('1, '0, '0, '1, '0, '0, '0, '0);
    apply('0, '1, '1, '0, '1, '0, '0, '0);
    apply('1, '0, '0, '0, '0, '1, '0, '0);
    // R7 R8: every wire forced low
    apply('1, '0, '0, '1, '1, '1, '1, '1);
    // R6 R7: random single-wire force-low faults
    for (int n = 0; n < 300; n++) begin
      logic [PW-1:0] m [5];
      int sel;
      for (int k = 0; k < 5; k++) m[k] = '0;
      sel = int'($urandom % 5);
      m[sel] = PW'(1) << ($urandom % PW);
      apply(L'($urandom), L'($urandom), L'($urandom), m[0], m[1], m[2], m[3], m[4]);
    end
    // R6 R7: random multi-wire masks
    for (int n = 0; n < 200; n++)
      apply(L'($urandom), L'($urandom), L'($urandom),
            PW'($urandom), PW'($urandom), PW'($urandom), PW'($urandom), PW'($urandom));
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule